// File: doc/BRIEF.md
# Rename Stage Stall and Squash Controller

This block is the control core of the rename stage of an out-of-order pipeline, built for a single thread. It decides each cycle whether an instruction coming from decode passes straight on, is parked in a small skid buffer, or is held back as a serializing instruction. It raises a block or an unblock strobe toward decode as those decisions change. Downstream resource checks ask it to stall through one input. The commit side reports that the reorder buffer has drained, and that report ends a serialize hold.

A squash carries a sequence number. Skid entries younger than that number are marked dead and are thrown away as the buffer drains. A squash does not always end in the running state. Two resume flags remember what the stage was doing. A serializing instruction that is not younger than the squash sends the stage back to the serialize hold. A skid buffer that still holds entries sends it back to unblocking. The first cycle after such a return blocks decode again. The block also counts the cycles spent blocked, squashing and serialize-stalled, and it raises a sticky error flag when a write arrives at a full skid buffer.

Top module: `rename_stall_ctl`

## Requirements
- R1: After reset the state output reads Idle and every counter reads zero. The skid buffer is empty, and the overflow, block and unblock outputs are low. The state codes are Idle=0, Running=1, Blocked=2, Unblocking=3, Squashing=4 and SerialHold=5.
- R2: In Idle or Running, with no stall request, a valid non-serializing input shows on the output in the same cycle with its sequence number. The next state is Running.
- R3: In Idle or Running, a stall request raises block in the same cycle. A valid input in that cycle goes into the skid buffer, and the next state is Blocked.
- R4: While Blocked, block stays low and valid inputs are still captured. When the stall request drops, the next state is Unblocking.
- R5: Unblocking drains one skid entry per cycle, oldest first. Once the buffer is empty and no input or stall is present, unblock pulses for one cycle and the next state is Running. A stall request in Unblocking moves the stage to Blocked.
- R6: A write to a full skid buffer is dropped, the occupancy stays at the depth, and the overflow output goes high and stays high until reset.
- R7: A squash always makes the next state Squashing and drops any input in that cycle. Skid entries whose sequence number is greater than the squash number leave the buffer during the drain without appearing on the output.
- R8: A squash in Blocked or Unblocking raises unblock in the same cycle, drops any held serializing instruction and clears the resume-serialize flag.
- R9: A squash in SerialHold keeps the held instruction and sets resume-serialize when the held number is less than or equal to the squash number. Otherwise it raises unblock in the same cycle and drops the held instruction.
- R10: When Squashing ends, the next state is SerialHold if resume-serialize is set. Otherwise it is Unblocking if the skid buffer was non-empty at the squash. Otherwise it is Running.
- R11: In the first SerialHold or Unblocking cycle whose resume flag is set, block is high and unblock is low, and the flag is cleared. Block and unblock are never high together.
- R12: A serializing input in Idle or Running is held, raises block and moves the stage to SerialHold. A serializing entry drained from the skid buffer also moves the stage to SerialHold. SerialHold ignores stall requests and never moves to Blocked. When the reorder buffer reports empty, the held instruction shows on the output and the next state is Unblocking.
- R13: The blocked, squashing and serialize counters each add one for every clock edge at which the state is Blocked, Squashing or SerialHold respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction from decode is valid |
| inSeq | input | SEQ_W | Sequence number of the incoming instruction |
| inSerial | input | 1 | Incoming instruction must serialize |
| stallReq | input | 1 | Downstream resource check requests a stall |
| squashValid | input | 1 | Squash request |
| squashSeq | input | SEQ_W | Youngest sequence number that survives the squash |
| robEmpty | input | 1 | Reorder buffer has drained; ends a serialize hold |
| outValid | output | 1 | An instruction leaves the stage this cycle |
| outSeq | output | SEQ_W | Sequence number of the leaving instruction |
| blockOut | output | 1 | Tell decode to block |
| unblockOut | output | 1 | Tell decode to unblock |
| stateOut | output | 3 | Current state code |
| skidCount | output | $clog2(DEPTH+1) | Skid buffer occupancy |
| overflowErr | output | 1 | Sticky skid overflow error |
| blockCycles | output | CNT_W | Cycles spent Blocked |
| squashCycles | output | CNT_W | Cycles spent Squashing |
| serialCycles | output | CNT_W | Cycles spent in SerialHold |

## Verification
Two functions can meet in one cycle. The first is a squash arriving while a resume is pending or while the stage is stalled. The second is the drain of a skid buffer that holds a mix of live and dead entries. The bench forces both cases directly. In one test a squash lands on a Blocked stage that holds three entries, and in another a squash lands on a serialize hold while a stall request and a skid entry are present. Each case is judged cycle by cycle: the unblock strobe in the squash cycle, the block strobe in the resume cycle, the order and content of the output, and the state taken after Squashing.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RUN    = 3'd1,
    ST_BLOCK  = 3'd2,
    ST_UNBLK  = 3'd3,
    ST_SQUASH = 3'd4,
    ST_SERIAL = 3'd5
  } rscState_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic squash;
  } skidCmd_t;
endpackage

// File: rtl/rsc_skid.sv
module rsc_skid
  import rsc_pkg::*;
#(
  parameter int SEQ_W = 8,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  skidCmd_t         cmd,
  input  logic [SEQ_W-1:0] pushSeq,
  input  logic             pushSerial,
  input  logic [SEQ_W-1:0] squashSeq,
  output logic [CW-1:0]    count,
  output logic [SEQ_W-1:0] headSeq,
  output logic             headSerial,
  output logic             headKill,
  output logic             overflowErr
);
  logic [SEQ_W-1:0] seqMem [DEPTH];
  logic [DEPTH-1:0] serMem;
  logic [DEPTH-1:0] killMem;
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic full, doPush, doPop;

  assign full   = (count == CW'(DEPTH));
  assign doPop  = cmd.pop && (count != '0);
  assign doPush = cmd.push && (!full || doPop);

  assign headSeq    = seqMem[rdPtr];
  assign headSerial = serMem[rdPtr];
  assign headKill   = killMem[rdPtr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr       <= '0;
      wrPtr       <= '0;
      count       <= '0;
      killMem     <= '0;
      serMem      <= '0;
      overflowErr <= 1'b0;
      for (int i = 0; i < DEPTH; i++) seqMem[i] <= '0;
    end else begin
      if (cmd.squash) begin
        for (int i = 0; i < DEPTH; i++)
          if (seqMem[i] > squashSeq) killMem[i] <= 1'b1;
      end
      if (doPush) begin
        seqMem[wrPtr]  <= pushSeq;
        serMem[wrPtr]  <= pushSerial;
        killMem[wrPtr] <= 1'b0;
        wrPtr          <= bump(wrPtr);
      end
      if (doPop) rdPtr <= bump(rdPtr);
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
      if (cmd.push && full && !doPop) overflowErr <= 1'b1;
    end
  end

  // R6
  skid_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
  // R6
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |=> overflowErr);
endmodule

// File: rtl/rsc_ctl.sv
module rsc_ctl
  import rsc_pkg::*;
#(
  parameter int SEQ_W = 8,
  parameter int DEPTH = 4,
  parameter int CNT_W = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [SEQ_W-1:0] inSeq,
  input  logic             inSerial,
  input  logic             stallReq,
  input  logic             squashValid,
  input  logic [SEQ_W-1:0] squashSeq,
  input  logic             robEmpty,
  input  logic [CW-1:0]    skidCount,
  input  logic [SEQ_W-1:0] headSeq,
  input  logic             headSerial,
  input  logic             headKill,
  output skidCmd_t         cmd,
  output logic             outValid,
  output logic [SEQ_W-1:0] outSeq,
  output logic             blockOut,
  output logic             unblockOut,
  output rscState_e        state,
  output logic [CNT_W-1:0] blockCycles,
  output logic [CNT_W-1:0] squashCycles,
  output logic [CNT_W-1:0] serialCycles
);
  rscState_e nxt;
  logic resSer, resSerNxt, resUnb, resUnbNxt;
  logic holdV, holdVNxt;
  logic [SEQ_W-1:0] holdS, holdSNxt;

  always_comb begin
    nxt        = state;
    cmd        = '0;
    outValid   = 1'b0;
    outSeq     = inSeq;
    blockOut   = 1'b0;
    unblockOut = 1'b0;
    resSerNxt  = resSer;
    resUnbNxt  = resUnb;
    holdVNxt   = holdV;
    holdSNxt   = holdS;
    if (squashValid) begin
      cmd.squash = 1'b1;
      nxt        = ST_SQUASH;
      resUnbNxt  = (skidCount != '0);
      if (state == ST_BLOCK || state == ST_UNBLK) begin
        unblockOut = 1'b1;
        resSerNxt  = 1'b0;
        holdVNxt   = 1'b0;
      end else if (state == ST_SERIAL) begin
        if (holdV && holdS <= squashSeq) begin
          resSerNxt = 1'b1;
        end else begin
          unblockOut = 1'b1;
          resSerNxt  = 1'b0;
          holdVNxt   = 1'b0;
        end
      end
    end else begin
      unique case (state)
        ST_IDLE, ST_RUN: begin
          if (stallReq) begin
            cmd.push = inValid;
            blockOut = 1'b1;
            nxt      = ST_BLOCK;
          end else if (inValid) begin
            if (inSerial) begin
              holdVNxt = 1'b1;
              holdSNxt = inSeq;
              blockOut = 1'b1;
              nxt      = ST_SERIAL;
            end else begin
              outValid = 1'b1;
              nxt      = ST_RUN;
            end
          end
        end
        ST_BLOCK: begin
          cmd.push = inValid;
          if (!stallReq) nxt = ST_UNBLK;
        end
        ST_UNBLK: begin
          cmd.push = inValid;
          if (resUnb) begin
            blockOut  = 1'b1;
            resUnbNxt = 1'b0;
          end
          if (stallReq) begin
            nxt = ST_BLOCK;
          end else if (skidCount != '0) begin
            cmd.pop = 1'b1;
            if (!headKill) begin
              if (headSerial) begin
                holdVNxt = 1'b1;
                holdSNxt = headSeq;
                nxt      = ST_SERIAL;
              end else begin
                outValid = 1'b1;
                outSeq   = headSeq;
              end
            end
          end else if (!inValid && !resUnb) begin
            unblockOut = 1'b1;
            nxt        = ST_RUN;
          end
        end
        ST_SQUASH: begin
          if (resSer)      nxt = ST_SERIAL;
          else if (resUnb) nxt = ST_UNBLK;
          else             nxt = ST_RUN;
        end
        ST_SERIAL: begin
          cmd.push = inValid;
          if (resSer) begin
            blockOut  = 1'b1;
            resSerNxt = 1'b0;
          end
          if (robEmpty) begin
            outValid = holdV;
            outSeq   = holdS;
            holdVNxt = 1'b0;
            nxt      = ST_UNBLK;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      resSer       <= 1'b0;
      resUnb       <= 1'b0;
      holdV        <= 1'b0;
      holdS        <= '0;
      blockCycles  <= '0;
      squashCycles <= '0;
      serialCycles <= '0;
    end else begin
      state  <= nxt;
      resSer <= resSerNxt;
      resUnb <= resUnbNxt;
      holdV  <= holdVNxt;
      holdS  <= holdSNxt;
      if (state == ST_BLOCK)  blockCycles  <= blockCycles + 1'b1;
      if (state == ST_SQUASH) squashCycles <= squashCycles + 1'b1;
      if (state == ST_SERIAL) serialCycles <= serialCycles + 1'b1;
    end
  end

  // R12
  serial_no_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SERIAL) |=> (state != ST_BLOCK));
  // R7
  squash_enter_chk: assert property (@(posedge clk) disable iff (!rstN)
    squashValid |=> (state == ST_SQUASH));
  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(blockOut && unblockOut));
  // R10
  squash_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SQUASH && !squashValid) |=>
      (state == ST_SERIAL || state == ST_UNBLK || state == ST_RUN));
  // R8
  squash_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (squashValid && state == ST_BLOCK) |-> unblockOut);
endmodule

// File: rtl/rename_stall_ctl.sv
module rename_stall_ctl
  import rsc_pkg::*;
#(
  parameter int SEQ_W = 8,
  parameter int DEPTH = 4,
  parameter int CNT_W = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [SEQ_W-1:0] inSeq,
  input  logic             inSerial,
  input  logic             stallReq,
  input  logic             squashValid,
  input  logic [SEQ_W-1:0] squashSeq,
  input  logic             robEmpty,
  output logic             outValid,
  output logic [SEQ_W-1:0] outSeq,
  output logic             blockOut,
  output logic             unblockOut,
  output logic [2:0]       stateOut,
  output logic [CW-1:0]    skidCount,
  output logic             overflowErr,
  output logic [CNT_W-1:0] blockCycles,
  output logic [CNT_W-1:0] squashCycles,
  output logic [CNT_W-1:0] serialCycles
);
  skidCmd_t         cmd;
  rscState_e        state;
  logic [SEQ_W-1:0] headSeq;
  logic             headSerial, headKill;

  assign stateOut = state;

  rsc_skid #(.SEQ_W(SEQ_W), .DEPTH(DEPTH)) u_skid (
    .clk(clk), .rstN(rstN), .cmd(cmd), .pushSeq(inSeq), .pushSerial(inSerial),
    .squashSeq(squashSeq), .count(skidCount), .headSeq(headSeq),
    .headSerial(headSerial), .headKill(headKill), .overflowErr(overflowErr)
  );

  rsc_ctl #(.SEQ_W(SEQ_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSeq(inSeq), .inSerial(inSerial),
    .stallReq(stallReq), .squashValid(squashValid), .squashSeq(squashSeq),
    .robEmpty(robEmpty), .skidCount(skidCount), .headSeq(headSeq),
    .headSerial(headSerial), .headKill(headKill), .cmd(cmd),
    .outValid(outValid), .outSeq(outSeq), .blockOut(blockOut),
    .unblockOut(unblockOut), .state(state), .blockCycles(blockCycles),
    .squashCycles(squashCycles), .serialCycles(serialCycles)
  );
endmodule

// File: tb/rename_stall_ctl_bench.sv
module rename_stall_ctl_bench;
  localparam int SEQ_W = 8;
  localparam int DEPTH = 4;
  localparam int CNT_W = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN;
  logic inValid, inSerial, stallReq, squashValid, robEmpty;
  logic [SEQ_W-1:0] inSeq, squashSeq;
  logic outValid, blockOut, unblockOut, overflowErr;
  logic [SEQ_W-1:0] outSeq;
  logic [2:0] stateOut;
  logic [CW-1:0] skidCount;
  logic [CNT_W-1:0] blockCycles, squashCycles, serialCycles;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rename_stall_ctl #(.SEQ_W(SEQ_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_rename_stall_ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSeq(inSeq), .inSerial(inSerial),
    .stallReq(stallReq), .squashValid(squashValid), .squashSeq(squashSeq),
    .robEmpty(robEmpty), .outValid(outValid), .outSeq(outSeq), .blockOut(blockOut),
    .unblockOut(unblockOut), .stateOut(stateOut), .skidCount(skidCount),
    .overflowErr(overflowErr), .blockCycles(blockCycles),
    .squashCycles(squashCycles), .serialCycles(serialCycles)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive inputs shortly after an edge, let combinational outputs settle
  task automatic drive(input logic v, input int seq, input logic ser, input logic st,
                       input logic sq, input int sqs, input logic rob);
    inValid = v; inSeq = SEQ_W'(seq); inSerial = ser; stallReq = st;
    squashValid = sq; squashSeq = SEQ_W'(sqs); robEmpty = rob;
    #2;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    idle();
    tick(); tick();
    rstN = 1'b1;
    idle();
  endtask

  task automatic t_reset();
    doReset();
    chk("R1", "state", stateOut, 0);
    chk("R1", "skidCount", skidCount, 0);
    chk("R1", "overflow", overflowErr, 0);
    chk("R1", "block", blockOut, 0);
    chk("R1", "unblock", unblockOut, 0);
    chk("R1", "blockCycles", blockCycles, 0);
    chk("R1", "serialCycles", serialCycles, 0);
  endtask

  task automatic t_pass();
    doReset();
    drive(1, 5, 0, 0, 0, 0, 0);
    chk("R2", "outValid", outValid, 1);
    chk("R2", "outSeq", outSeq, 5);
    tick();
    chk("R2", "state", stateOut, 1);
    drive(1, 6, 0, 0, 0, 0, 0);
    chk("R2", "outSeq run", outSeq, 6);
    tick();
  endtask

  task automatic t_block();
    doReset();
    drive(1, 10, 0, 1, 0, 0, 0);
    chk("R3", "block", blockOut, 1);
    chk("R3", "outValid", outValid, 0);
    tick();
    chk("R3", "state", stateOut, 2);
    chk("R3", "count", skidCount, 1);
    drive(1, 11, 0, 1, 0, 0, 0);
    chk("R4", "block while blocked", blockOut, 0);
    tick();
    chk("R4", "count", skidCount, 2);
    idle();
    tick();
    chk("R4", "state unblocking", stateOut, 3);
    chk("R13", "blockCycles", blockCycles, 2);
    idle();
    chk("R5", "drain1 valid", outValid, 1);
    chk("R5", "drain1 seq", outSeq, 10);
    tick(); idle();
    chk("R5", "drain2 seq", outSeq, 11);
    tick(); idle();
    chk("R5", "unblock", unblockOut, 1);
    tick();
    chk("R5", "state run", stateOut, 1);
  endtask

  task automatic t_overflow();
    doReset();
    for (int i = 0; i < DEPTH + 1; i++) begin
      drive(1, 70 + i, 0, 1, 0, 0, 0);
      tick();
    end
    idle();
    chk("R6", "count", skidCount, DEPTH);
    chk("R6", "overflow", overflowErr, 1);
    drive(0, 0, 0, 1, 0, 0, 0);
    tick();
    chk("R6", "sticky", overflowErr, 1);
  endtask

  task automatic t_squashSkid();
    doReset();
    for (int i = 0; i < 3; i++) begin
      drive(1, 20 + i, 0, 1, 0, 0, 0);
      tick();
    end
    drive(1, 99, 0, 1, 1, 20, 0);
    chk("R8", "unblock on squash", unblockOut, 1);
    chk("R7", "no output on squash", outValid, 0);
    tick();
    chk("R7", "state squashing", stateOut, 4);
    chk("R7", "input dropped", skidCount, 3);
    idle();
    tick();
    chk("R10", "to unblocking", stateOut, 3);
    idle();
    chk("R11", "resume block", blockOut, 1);
    chk("R11", "resume no unblock", unblockOut, 0);
    chk("R7", "live head valid", outValid, 1);
    chk("R7", "live head seq", outSeq, 20);
    tick(); idle();
    chk("R7", "dead 21 hidden", outValid, 0);
    chk("R11", "flag cleared", blockOut, 0);
    tick(); idle();
    chk("R7", "dead 22 hidden", outValid, 0);
    tick(); idle();
    chk("R5", "unblock after drain", unblockOut, 1);
    tick();
    chk("R5", "running", stateOut, 1);
    chk("R13", "squashCycles", squashCycles, 1);
  endtask

  task automatic t_squashEmpty();
    doReset();
    drive(0, 0, 0, 1, 0, 0, 0);
    tick();
    drive(0, 0, 0, 1, 1, 3, 0);
    chk("R8", "unblock", unblockOut, 1);
    tick(); idle();
    tick();
    chk("R10", "to running", stateOut, 1);
  endtask

  task automatic t_serialResume();
    doReset();
    drive(1, 30, 1, 0, 0, 0, 0);
    chk("R12", "block on serial", blockOut, 1);
    chk("R12", "held not output", outValid, 0);
    tick();
    chk("R12", "serial state", stateOut, 5);
    drive(1, 31, 0, 1, 0, 0, 0);
    tick();
    chk("R12", "stall ignored", stateOut, 5);
    drive(0, 0, 0, 0, 1, 40, 0);
    chk("R9", "no unblock older hold", unblockOut, 0);
    tick(); idle();
    tick();
    chk("R10", "back to serial", stateOut, 5);
    idle();
    chk("R11", "resume block", blockOut, 1);
    chk("R11", "resume no unblock", unblockOut, 0);
    tick();
    drive(0, 0, 0, 0, 0, 0, 1);
    chk("R12", "release valid", outValid, 1);
    chk("R12", "release seq", outSeq, 30);
    tick();
    chk("R12", "unblocking", stateOut, 3);
    chk("R13", "serialCycles", serialCycles, 4);
    idle();
    chk("R11", "unblock resume", blockOut, 1);
    chk("R5", "skid entry", outSeq, 31);
    tick(); idle();
    chk("R5", "unblock", unblockOut, 1);
    tick();
  endtask

  task automatic t_serialYounger();
    doReset();
    drive(1, 50, 1, 0, 0, 0, 0);
    tick();
    drive(0, 0, 0, 0, 1, 45, 0);
    chk("R9", "unblock younger hold", unblockOut, 1);
    tick(); idle();
    tick();
    chk("R10", "to running", stateOut, 1);
    drive(0, 0, 0, 0, 0, 0, 1);
    chk("R9", "hold dropped", outValid, 0);
    tick();
  endtask

  task automatic t_serialFromSkid();
    doReset();
    drive(1, 60, 1, 1, 0, 0, 0);
    tick();
    idle();
    tick();
    idle();
    chk("R12", "skid serial not output", outValid, 0);
    tick();
    chk("R12", "serial from skid", stateOut, 5);
    drive(0, 0, 0, 0, 0, 0, 1);
    chk("R12", "skid serial release", outSeq, 60);
    tick();
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    idle();
    t_reset();
    t_pass();
    t_block();
    t_overflow();
    t_squashSkid();
    t_squashEmpty();
    t_serialResume();
    t_serialYounger();
    t_serialFromSkid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule